// File: doc/BRIEF.md
# Message-signalled interrupt dispatcher

This block sits after the per-source interrupt gateway. It sweeps the gateway's pending and enable vectors one source per cycle, in ascending order. When the domain-wide interrupt enable is on and it finds a source that is both pending and enabled, it turns that source into an outbound message. Each message carries a hart index, a guest index and an interrupt identity. These come from a per-source target word held inside the block. In the same cycle the block strobes a pending-clear line back to the gateway, so that sending a message consumes the pending bit.

Software can also post a message directly. It does this by writing a generate-message register. The value written is kept with its guest-index field zeroed, and one message goes out to the written hart with guest index 0.

The message leaves on a valid/ready port and stays there until accepted. Any accepted register write restarts the sweep from source 1, so every source gets a fresh look after configuration changes. Source 0 does not exist and is never dispatched.

Top module: `msi_dispatch`

## Requirements
- R1: While `dom_ie` is 0 no source message is loaded; pending bits in the gateway are left untouched and are dispatched once `dom_ie` returns to 1.
- R2: A source is loaded only when its `src_pend` and `src_en` bits are both 1. In that same cycle exactly one `pend_clr` bit, the one at that source's position, is 1, and `msg_valid` is 1 in the following cycle.
- R3: A source message takes its fields from the source's target word: hart index = bits 31:18, guest index = bits 17:12, identity = bits 10:0.
- R4: A target write keeps bits 31:18, 17:12 and 10:0 and stores bit 11 as 0. A write to index 0 is ignored, and a read of index 0 returns 0.
- R5: A pulse on `reg_wr`, `tgt_wr` or `gen_wr` restarts the sweep at source 1. The sweep then visits sources 1..NSRC-1 in ascending order, so simultaneous candidates leave in ascending index order.
- R6: A write to the generate register stores the written value with bits 17:12 cleared, readable on `gen_rd_data`.
- R7: A generate write sends one message with hart = bits 31:18 of the value, guest = 0 and identity = bits 10:0. A waiting generate message wins the output over any source candidate.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, the message fields stay unchanged and `msg_valid` stays 1.
- R9: While the output is stalled, later candidates are not cleared. They are delivered in order once the output drains.
- R10: Source 0 is never dispatched: `pend_clr[0]` is always 0, even when bit 0 of both vectors is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_ie | input | 1 | Domain-wide interrupt enable |
| reg_wr | input | 1 | Pulse: some other register write was accepted |
| src_pend | input | NSRC | Pending vector from the gateway |
| src_en | input | NSRC | Enable vector from the gateway |
| pend_clr | output | NSRC | One-cycle clear strobe for the dispatched source |
| tgt_wr | input | 1 | Target word write strobe |
| tgt_wr_idx | input | IDX_W | Source index of the target write |
| tgt_wr_data | input | 32 | Target word write data |
| tgt_rd_idx | input | IDX_W | Source index for target read-back |
| tgt_rd_data | output | 32 | Stored target word (masked) |
| gen_wr | input | 1 | Generate-message register write strobe |
| gen_wr_data | input | 32 | Generate-message write data |
| gen_rd_data | output | 32 | Stored generate-message value |
| msg_valid | output | 1 | Message present on the output |
| msg_ready | input | 1 | Output accepts the message |
| msg_hart | output | 14 | Message hart index |
| msg_guest | output | 6 | Message guest index |
| msg_eiid | output | 11 | Message interrupt identity |

## Verification
On every cycle, the bound checker confirms several local rules. A source is only consumed when the domain enable is on and its pending and enabled bits are set. The clear strobe is one-hot and never touches source 0. A stalled message holds still. A generate message carries guest 0 and never shares a cycle with a source clear. The bench scenarios cover what no single cycle can show: the ascending order of delivery after a restart, the exact field values derived from each target word, the masking of stored words, and that blocked or disabled candidates survive until they can be delivered.

// File: rtl/msi_disp_pkg.sv
`timescale 1ns/1ps
package msi_disp_pkg;
  localparam int WORD_W    = 32;
  localparam int HART_LSB  = 18;
  localparam int HART_W    = 14;
  localparam int GUEST_LSB = 12;
  localparam int GUEST_W   = 6;
  localparam int EIID_LSB  = 0;
  localparam int EIID_W    = 11;

  typedef struct packed {
    logic [HART_W-1:0]  hart;
    logic [GUEST_W-1:0] guest;
    logic [EIID_W-1:0]  eiid;
  } msi_msg_t;

  // Pull the three routing fields out of a register word.
  function automatic msi_msg_t field_split(input logic [WORD_W-1:0] w);
    msi_msg_t m;
    m.hart  = w[HART_LSB +: HART_W];
    m.guest = w[GUEST_LSB +: GUEST_W];
    m.eiid  = w[EIID_LSB +: EIID_W];
    return m;
  endfunction

  // Rebuild a register word; bits outside the fields read as zero.
  function automatic logic [WORD_W-1:0] field_join(input msi_msg_t m);
    logic [WORD_W-1:0] w;
    w = '0;
    w[HART_LSB +: HART_W]   = m.hart;
    w[GUEST_LSB +: GUEST_W] = m.guest;
    w[EIID_LSB +: EIID_W]   = m.eiid;
    return w;
  endfunction

  // Generate-register value: everything kept except the guest field.
  function automatic logic [WORD_W-1:0] gen_keep(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[GUEST_LSB +: GUEST_W] = '0;
    return r;
  endfunction
endpackage

// File: rtl/msi_tgt_store.sv
`timescale 1ns/1ps
module msi_tgt_store
  import msi_disp_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDX_W = $clog2(NSRC),
  localparam int SLOTS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic [IDX_W-1:0]  scan_idx,
  output msi_msg_t          scan_msg
);
  logic [SLOTS-1:0] live;
  msi_msg_t ent [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_live
    assign live[i] = (i != 0) && (i < NSRC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) ent[k] <= '0;
    end else if (wr_en && live[wr_idx]) begin
      ent[wr_idx] <= field_split(wr_data);
    end
  end

  assign rd_word  = live[rd_idx] ? field_join(ent[rd_idx]) : '0;
  assign scan_msg = ent[scan_idx];
endmodule

// File: rtl/msi_scan.sv
`timescale 1ns/1ps
module msi_scan #(
  parameter int NSRC = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             dom_ie,
  input  logic [NSRC-1:0]  src_pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic             slot_free,
  input  logic             gen_busy,
  output logic [IDX_W-1:0] ptr,
  output logic             load,
  output logic [NSRC-1:0]  pend_clr
);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NSRC - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? FIRST : p + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] ptr_q;
  logic hit;

  assign hit  = dom_ie & src_pend[ptr_q] & src_en[ptr_q];
  assign load = hit & slot_free & ~gen_busy;
  assign ptr  = ptr_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign pend_clr[i] = load && (ptr_q == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ptr_q <= FIRST;
    else if (restart)        ptr_q <= FIRST;
    else if (hit && !load)   ptr_q <= ptr_q;
    else                     ptr_q <= step(ptr_q);
  end
endmodule

// File: rtl/msi_out_slot.sv
`timescale 1ns/1ps
module msi_out_slot
  import msi_disp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  msi_msg_t load_msg,
  input  logic     ready,
  output logic     valid,
  output msi_msg_t msg,
  output logic     free
);
  assign free = ~valid | ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      msg   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      msg   <= load_msg;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_dispatch.sv
`timescale 1ns/1ps
module msi_dispatch
  import msi_disp_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dom_ie,
  input  logic               reg_wr,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [NSRC-1:0]    src_en,
  output logic [NSRC-1:0]    pend_clr,
  input  logic               tgt_wr,
  input  logic [IDX_W-1:0]   tgt_wr_idx,
  input  logic [WORD_W-1:0]  tgt_wr_data,
  input  logic [IDX_W-1:0]   tgt_rd_idx,
  output logic [WORD_W-1:0]  tgt_rd_data,
  input  logic               gen_wr,
  input  logic [WORD_W-1:0]  gen_wr_data,
  output logic [WORD_W-1:0]  gen_rd_data,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [HART_W-1:0]  msg_hart,
  output logic [GUEST_W-1:0] msg_guest,
  output logic [EIID_W-1:0]  msg_eiid
);
  logic [IDX_W-1:0]  scan_ptr;
  msi_msg_t          scan_msg;
  logic              slot_free;
  logic              load_scan;
  logic              load_gen;
  logic              restart;
  msi_msg_t          slot_in;
  msi_msg_t          slot_msg;
  logic [WORD_W-1:0] gen_q;
  msi_msg_t          gen_msg_q;
  logic              gen_pend_q;

  assign restart  = reg_wr | tgt_wr | gen_wr;
  assign load_gen = gen_pend_q & slot_free;
  assign slot_in  = load_gen ? gen_msg_q : scan_msg;

  msi_tgt_store #(.NSRC(NSRC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tgt_wr), .wr_idx(tgt_wr_idx), .wr_data(tgt_wr_data),
    .rd_idx(tgt_rd_idx), .rd_word(tgt_rd_data),
    .scan_idx(scan_ptr), .scan_msg(scan_msg)
  );

  msi_scan #(.NSRC(NSRC)) u_scan (
    .clk(clk), .rst_n(rst_n), .restart(restart), .dom_ie(dom_ie),
    .src_pend(src_pend), .src_en(src_en), .slot_free(slot_free),
    .gen_busy(gen_pend_q), .ptr(scan_ptr), .load(load_scan),
    .pend_clr(pend_clr)
  );

  msi_out_slot u_slot (
    .clk(clk), .rst_n(rst_n), .load(load_scan | load_gen),
    .load_msg(slot_in), .ready(msg_ready), .valid(msg_valid),
    .msg(slot_msg), .free(slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q      <= '0;
      gen_msg_q  <= '0;
      gen_pend_q <= 1'b0;
    end else if (gen_wr) begin
      gen_q      <= gen_keep(gen_wr_data);
      gen_msg_q  <= field_split(gen_keep(gen_wr_data));
      gen_pend_q <= 1'b1;
    end else if (load_gen) begin
      gen_pend_q <= 1'b0;
    end
  end

  assign gen_rd_data = gen_q;
  assign msg_hart    = slot_msg.hart;
  assign msg_guest   = slot_msg.guest;
  assign msg_eiid    = slot_msg.eiid;
endmodule

// File: rtl/msi_dispatch_chk.sv
`timescale 1ns/1ps
module msi_dispatch_chk
  import msi_disp_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dom_ie,
  input logic [NSRC-1:0]    src_pend,
  input logic [NSRC-1:0]    src_en,
  input logic [NSRC-1:0]    pend_clr,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [HART_W-1:0]  msg_hart,
  input logic [GUEST_W-1:0] msg_guest,
  input logic [EIID_W-1:0]  msg_eiid,
  input logic               load_scan,
  input logic               load_gen
);
  a_r1_no_load_without_ie: assert property (@(posedge clk) disable iff (!rst_n)
    load_scan |-> dom_ie);

  a_r2_clr_only_pend_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr != '0) |-> ((pend_clr & ~(src_pend & src_en)) == '0));

  a_r2_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));

  a_r2_clr_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr != '0) |=> msg_valid);

  a_r10_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_clr[0]);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hart)
                                   && $stable(msg_guest) && $stable(msg_eiid)));

  a_r7_gen_guest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load_gen |=> (msg_valid && msg_guest == '0));

  a_r7_gen_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_gen |-> (pend_clr == '0));
endmodule

bind msi_dispatch msi_dispatch_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .src_pend(src_pend),
  .src_en(src_en), .pend_clr(pend_clr), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_hart(msg_hart), .msg_guest(msg_guest),
  .msg_eiid(msg_eiid), .load_scan(load_scan), .load_gen(load_gen)
);

// File: tb/msi_dispatch_tb.sv
`timescale 1ns/1ps
module msi_dispatch_tb;
  localparam int NSRC = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dom_ie = 1'b0, reg_wr = 1'b0, tgt_wr = 1'b0, gen_wr = 1'b0, msg_ready = 1'b0;
  logic [NSRC-1:0] pend_q, pset = '0, src_en = '0, pend_clr;
  logic [IW-1:0] tgt_wr_idx = '0, tgt_rd_idx = '0;
  logic [31:0] tgt_wr_data = '0, gen_wr_data = '0, tgt_rd_data, gen_rd_data;
  logic msg_valid;
  logic [13:0] msg_hart;
  logic [5:0] msg_guest;
  logic [10:0] msg_eiid;

  int total = 0, bad = 0, lg_n = 0;
  logic [13:0] lg_h [64];
  logic [5:0]  lg_g [64];
  logic [10:0] lg_e [64];

  always #4 clk = ~clk;

  msi_dispatch #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie), .reg_wr(reg_wr),
    .src_pend(pend_q), .src_en(src_en), .pend_clr(pend_clr),
    .tgt_wr(tgt_wr), .tgt_wr_idx(tgt_wr_idx), .tgt_wr_data(tgt_wr_data),
    .tgt_rd_idx(tgt_rd_idx), .tgt_rd_data(tgt_rd_data),
    .gen_wr(gen_wr), .gen_wr_data(gen_wr_data), .gen_rd_data(gen_rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_hart(msg_hart),
    .msg_guest(msg_guest), .msg_eiid(msg_eiid)
  );

  // Gateway model: pending bits set by the bench, cleared by the strobe.
  always @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | pset;
  end

  // Handshake monitor, sampled between edges.
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && lg_n < 64) begin
      lg_h[lg_n] = msg_hart;
      lg_g[lg_n] = msg_guest;
      lg_e[lg_n] = msg_eiid;
      lg_n++;
    end
  end

  function automatic int t_hart(int i);  return i * 3 + 100; endfunction
  function automatic int t_guest(int i); return i + 1;       endfunction
  function automatic int t_eiid(int i);  return i * 17 + 5;  endfunction
  function automatic logic [31:0] tword(int i);
    return 32'((t_hart(i) << 18) + (t_guest(i) << 12) + t_eiid(i));
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) tick(); endtask
  task automatic settle(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_msg(string req, int k, int h, int g, int e);
    chk(req, 32'(lg_h[k]), 32'(h));
    chk(req, 32'(lg_g[k]), 32'(g));
    chk(req, 32'(lg_e[k]), 32'(e));
  endtask

  task automatic chk_src(string req, int k, int s);
    chk_msg(req, k, t_hart(s), t_guest(s), t_eiid(s));
  endtask

  task automatic wr_tgt(int i, logic [31:0] d);
    tgt_wr = 1'b1; tgt_wr_idx = IW'(i); tgt_wr_data = d; tick(); tgt_wr = 1'b0;
  endtask

  task automatic rd_tgt(int i, output logic [31:0] d);
    tgt_rd_idx = IW'(i); settle(); d = tgt_rd_data; tick();
  endtask

  task automatic wr_gen(logic [31:0] d);
    gen_wr = 1'b1; gen_wr_data = d; tick(); gen_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] g2;
    int n0;
    idle(3);
    rst_n = 1'b1;
    tick();
    // Reset state
    settle();
    chk("reset msg_valid", 32'(msg_valid), 0);
    chk("reset pend_clr", 32'(pend_clr), 0);
    chk("reset gen_rd", gen_rd_data, 0);
    tick();
    rd_tgt(5, d); chk("reset tgt R4", d, 0);

    // R4: masking of stored target words and index 0 ignored
    wr_tgt(3, 32'hFFFF_FFFF);
    rd_tgt(3, d); chk("R4 mask all-ones", d, 32'hFFFF_F7FF);
    wr_tgt(0, 32'hFFFF_FFFF);
    rd_tgt(0, d); chk("R4 index 0", d, 0);
    for (int i = 1; i < NSRC; i++) wr_tgt(i, tword(i) | 32'h0000_0800);
    for (int i = 1; i < NSRC; i++) begin
      rd_tgt(i, d); chk("R4 sweep readback", d, tword(i));
    end

    // R1: nothing leaves while the domain enable is off
    msg_ready = 1'b1;
    src_en = 8'hAE;
    pset = 8'hFF; tick(); pset = '0;
    idle(20);
    settle();
    chk("R1 no message ie=0", 32'(lg_n), 0);
    chk("R1 pending kept", 32'(pend_q), 32'hFF);
    tick();

    // R5/R2/R3/R10: restart then enable, ascending delivery of 1,2,3,5,7
    reg_wr = 1'b1; tick(); reg_wr = 1'b0;
    dom_ie = 1'b1;
    idle(30);
    settle();
    chk("R5 count", 32'(lg_n), 5);
    chk_src("R5 R3 order src1", 0, 1);
    chk_src("R5 R3 order src2", 1, 2);
    chk_src("R5 R3 order src3", 2, 3);
    chk_src("R5 R3 order src5", 3, 5);
    chk_src("R5 R3 order src7", 4, 7);
    chk("R2 R10 disabled and src0 kept", 32'(pend_q), 32'h51);
    tick();

    // R8/R9: stall the output with two new candidates
    msg_ready = 1'b0;
    reg_wr = 1'b1; tick(); reg_wr = 1'b0;
    src_en = 8'hFF;
    idle(15);
    settle();
    chk("R8 valid while stalled", 32'(msg_valid), 1);
    chk("R8 R3 stalled hart", 32'(msg_hart), 32'(t_hart(4)));
    chk("R9 later candidate kept", 32'(pend_q), 32'h41);
    tick();
    idle(5);
    settle();
    chk("R8 fields stable", 32'(msg_eiid), 32'(t_eiid(4)));
    chk("R9 still kept", 32'(pend_q), 32'h41);
    tick();
    msg_ready = 1'b1;
    idle(15);
    settle();
    chk("R9 drained count", 32'(lg_n), 7);
    chk_src("R9 first after stall", 5, 4);
    chk_src("R9 second after stall", 6, 6);
    chk("R10 src0 never sent", 32'(pend_q), 32'h01);
    tick();

    // R1: domain enable off again holds a new pending bit
    dom_ie = 1'b0;
    pset = 8'h20; tick(); pset = '0;
    idle(12);
    settle();
    chk("R1 held count", 32'(lg_n), 7);
    chk("R1 held pend", 32'(pend_q), 32'h21);
    tick();
    dom_ie = 1'b1;
    idle(12);
    settle();
    chk("R1 released", 32'(lg_n), 8);
    chk_src("R1 released src5", 7, 5);
    tick();

    // R6/R7: generate message queued behind a stalled source message
    msg_ready = 1'b0;
    pset = 8'h04; tick(); pset = '0;
    idle(10);
    wr_gen(32'hFFFF_FFFF);
    idle(4);
    settle();
    chk("R6 gen readback", gen_rd_data, 32'hFFFC_0FFF);
    tick();
    msg_ready = 1'b1;
    idle(10);
    settle();
    chk("R7 count", 32'(lg_n), 10);
    chk_src("R7 source first", 8, 2);
    chk_msg("R7 gen fields", 9, 16'h3FFF, 0, 16'h7FF);
    tick();

    // R7: generate message wins over a simultaneous source candidate
    msg_ready = 1'b0;
    g2 = 32'h1234_5678;
    gen_wr = 1'b1; gen_wr_data = g2; pset = 8'h08; tick();
    gen_wr = 1'b0; pset = '0;
    idle(8);
    settle();
    chk("R6 gen readback 2", gen_rd_data, g2 & ~(32'h3F << 12));
    tick();
    n0 = lg_n;
    msg_ready = 1'b1;
    idle(10);
    settle();
    chk("R7 prio count", 32'(lg_n - n0), 2);
    chk_msg("R7 gen first", n0, int'(g2 >> 18), 0, int'(g2 & 32'h7FF));
    chk_src("R7 source after gen", n0 + 1, 3);
    tick();

    finish_run();
  end
endmodule